// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

The block is a W-bit storage register (eight bits by default) that does one of four things on each rising clock edge: it keeps its value, shifts toward the most significant bit, shifts toward the least significant bit, or loads a whole word from the shared parallel bus. A two-bit select input picks the operation. An active-low clear empties the register at once, without waiting for the clock.

The parallel bus is shared between loading and reading. On a real pad it is one set of pins. Here it is split into three parts: an input word, an output word and a single drive-enable bit, so that the surrounding logic or a pad ring can build the tri-state buffer. The bus is driven only when both active-low enable inputs are low and the block is not loading. During a load the bus is released so that an outside source can put the load word on it.

The lowest and highest stages also have their own serial outputs. These are never disabled, so several blocks can be chained through their serial inputs into a longer shift word.

Top module: `ushift_reg`

## Requirements
- R1: While `clr_n` is low, every register bit is 0 and stays 0, whatever the select inputs and the clock do. The clear takes effect as soon as `clr_n` falls, with no clock edge needed.
- R2: With `sel` = 2'b00, a rising clock edge leaves the register unchanged.
- R3: With `sel` = 2'b01, a rising clock edge moves each bit n to bit n+1 and puts `ser_r_in` into bit 0.
- R4: With `sel` = 2'b10, a rising clock edge moves each bit n to bit n-1 and puts `ser_l_in` into bit W-1.
- R5: With `sel` = 2'b11, a rising clock edge copies `bus_in` into the register.
- R6: `bus_drive` is 1 only when `en_a_n` and `en_b_n` are both 0 and `sel` is not 2'b11. In every other case it is 0.
- R7: `bus_out` always shows the register contents, and hold, shift, load and clear work the same whether `bus_drive` is 0 or 1.
- R8: `tap_lo` always equals bit 0 and `tap_hi` always equals bit W-1, whatever the values of the enable inputs.
- R9: When two blocks are chained (the low block's `tap_hi` feeds the high block's `ser_r_in`, and the high block's `tap_lo` feeds the low block's `ser_l_in`), they shift together as one 2W-bit register in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all operations except clear happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_r_in | input | 1 | Serial bit that enters bit 0 on an upward shift |
| ser_l_in | input | 1 | Serial bit that enters bit W-1 on a downward shift |
| en_a_n | input | 1 | Bus drive enable, active low |
| en_b_n | input | 1 | Second bus drive enable, active low |
| bus_in | input | W | Word sampled from the shared bus during a load |
| bus_out | output | W | Register contents for the shared bus |
| bus_drive | output | 1 | High when the shared bus must be driven with `bus_out` |
| tap_lo | output | 1 | Bit 0, always driven |
| tap_hi | output | 1 | Bit W-1, always driven |

## Verification
The assertions check on every clock edge that each of the four operations leaves the register holding the value it should. They also check that the register stays zero while the clear is low, and that the bus never has drive turned on while it is disabled or while a load is in progress. Only the bench scenarios can show two things that no edge-sampled property sees: that the clear takes hold between clock edges, and that the serial taps and the data path behave the same when the bus enables are off. Only a bench scenario can show that two chained blocks shift as one 16-bit word in both directions.

// File: rtl/ushift_reg.sv
module ushift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   sel,
  input  logic         ser_r_in,
  input  logic         ser_l_in,
  input  logic         en_a_n,
  input  logic         en_b_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_drive,
  output logic         tap_lo,
  output logic         tap_hi
);

  localparam logic [1:0] OP_HOLD = 2'b00;
  localparam logic [1:0] OP_UP   = 2'b01;
  localparam logic [1:0] OP_DOWN = 2'b10;
  localparam logic [1:0] OP_LOAD = 2'b11;

  logic [W-1:0] q;
  logic [W-1:0] q_nxt;

  always_comb begin
    unique case (sel)
      OP_UP:   q_nxt = {q[W-2:0], ser_r_in};
      OP_DOWN: q_nxt = {ser_l_in, q[W-1:1]};
      OP_LOAD: q_nxt = bus_in;
      default: q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end

  assign bus_out   = q;
  assign bus_drive = ~en_a_n & ~en_b_n & (sel != OP_LOAD);
  assign tap_lo    = q[0];
  assign tap_hi    = q[W-1];

  AST_CLEAR_ZERO: assert property (@(posedge clk) !clr_n |-> (bus_out == '0)); // R1
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == OP_HOLD) |=> (bus_out == $past(bus_out))); // R2
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == OP_UP) |=> (bus_out == {$past(bus_out[W-2:0]), $past(ser_r_in)})); // R3
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == OP_DOWN) |=> (bus_out == {$past(ser_l_in), $past(bus_out[W-1:1])})); // R4
  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == OP_LOAD) |=> (bus_out == $past(bus_in))); // R5
  AST_NO_DRIVE_OFF: assert property (@(posedge clk) disable iff (!clr_n)
    (en_a_n || en_b_n) |-> !bus_drive); // R6
  AST_NO_DRIVE_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == OP_LOAD) |-> !bus_drive); // R6

endmodule

// File: tb/ushift_reg_bench.sv
module ushift_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         clr_n = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic         sr = 1'b0, sl = 1'b0, ea = 1'b0, eb = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         drv, tlo, thi;

  ushift_reg #(.W(W)) u_ushift_reg (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_r_in(sr), .ser_l_in(sl),
    .en_a_n(ea), .en_b_n(eb), .bus_in(din), .bus_out(dout),
    .bus_drive(drv), .tap_lo(tlo), .tap_hi(thi));

  logic [W-1:0] c_in_lo = '0, c_in_hi = '0, c_out_lo, c_out_hi;
  logic         c_sr = 1'b0, c_sl = 1'b0;
  logic         lo_thi, lo_tlo, hi_thi, hi_tlo, lo_drv, hi_drv;

  ushift_reg #(.W(W)) u_lo (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_r_in(c_sr), .ser_l_in(hi_tlo),
    .en_a_n(1'b0), .en_b_n(1'b0), .bus_in(c_in_lo), .bus_out(c_out_lo),
    .bus_drive(lo_drv), .tap_lo(lo_tlo), .tap_hi(lo_thi));
  ushift_reg #(.W(W)) u_hi (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_r_in(lo_thi), .ser_l_in(c_sl),
    .en_a_n(1'b0), .en_b_n(1'b0), .bus_in(c_in_hi), .bus_out(c_out_hi),
    .bus_drive(hi_drv), .tap_lo(hi_tlo), .tap_hi(hi_thi));

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] m;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset value", dout, '0);
    chk("R8 reset taps", {tlo, thi}, 2'b00);
    @(negedge clk); clr_n = 1'b1;
  endtask

  task automatic t_load();
    ea = 1'b1; sel = 2'b11; din = 8'hA5; step();
    m = 8'hA5; chk("R5 load A5", dout, m);
    chk("R8 taps after load", {thi, tlo}, {m[W-1], m[0]});
    din = 8'h3C; step();
    m = 8'h3C; chk("R5 load 3C", dout, m);
    ea = 1'b0;
  endtask

  task automatic t_hold();
    sel = 2'b00; din = 8'hFF; sr = 1'b1; sl = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R2 hold", dout, m);
    end
  endtask

  task automatic t_shift_up();
    sel = 2'b01;
    for (int i = 0; i < 10; i++) begin
      sr = (i % 3 == 0);
      m = {m[W-2:0], sr};
      step(); chk("R3 shift up", dout, m);
      chk("R8 tap_lo up", tlo, m[0]);
    end
  endtask

  task automatic t_shift_down();
    sel = 2'b10;
    for (int i = 0; i < 10; i++) begin
      sl = (i % 2 == 1);
      m = {sl, m[W-1:1]};
      step(); chk("R4 shift down", dout, m);
      chk("R8 tap_hi down", thi, m[W-1]);
    end
  endtask

  task automatic t_drive();
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 4; e++) begin
        sel = s[1:0]; {ea, eb} = e[1:0]; #1;
        chk("R6 drive enable", drv, (e == 0) && (s != 3));
      end
    sel = 2'b00; ea = 1'b1; eb = 1'b1;
    @(negedge clk);
    sel = 2'b11; din = 8'h81; step(); m = 8'h81;
    chk("R7 load while released", dout, m);
    sel = 2'b01; sr = 1'b1; step(); m = {m[W-2:0], 1'b1};
    chk("R7 shift while released", dout, m);
    chk("R8 taps while released", {thi, tlo}, {m[W-1], m[0]});
    sel = 2'b10; sl = 1'b0; step(); m = {1'b0, m[W-1:1]};
    chk("R7 down while released", dout, m);
    sel = 2'b00; ea = 1'b0; eb = 1'b0;
  endtask

  task automatic t_async_clear();
    sel = 2'b11; din = 8'hEE; step();
    chk("R5 preload", dout, 8'hEE);
    #2 clr_n = 1'b0; #1;
    chk("R1 mid-cycle clear", dout, '0);
    chk("R1 taps cleared", {thi, tlo}, 2'b00);
    step();
    chk("R1 clear beats load", dout, '0);
    @(negedge clk); clr_n = 1'b1; sel = 2'b00;
    step(); chk("R1 stays zero after release", dout, '0);
    m = '0;
  endtask

  task automatic t_cascade();
    logic [2*W-1:0] w;
    sel = 2'b11; c_in_lo = 8'h5A; c_in_hi = 8'hC3; step();
    w = 16'hC35A;
    chk("R9 cascade load", {c_out_hi, c_out_lo}, w);
    sel = 2'b01;
    for (int i = 0; i < 12; i++) begin
      c_sr = (i % 4 == 1);
      w = {w[2*W-2:0], c_sr};
      step(); chk("R9 cascade up", {c_out_hi, c_out_lo}, w);
    end
    sel = 2'b10;
    for (int i = 0; i < 12; i++) begin
      c_sl = (i % 3 != 0);
      w = {c_sl, w[2*W-1:1]};
      step(); chk("R9 cascade down", {c_out_hi, c_out_lo}, w);
    end
    sel = 2'b00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired got=1 exp=0");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_load();
    t_hold();
    t_shift_up();
    t_shift_down();
    t_drive();
    t_async_clear();
    t_cascade();
    finish_run();
  end
endmodule